// File: doc/BRIEF.md
# March Algorithm Memory Self-Test Sequencer

This block is a built-in self-test sequencer for a single-port memory of 2^ADDR_W words. Once started, it steps through one of six selectable march algorithms. Each algorithm is a list of march elements. An element has its own address direction and a short list of read and write operations. The sequencer drives the memory address, write enable, read enable and write data. It checks every read against the value the algorithm expects, and reports the test result as pass or fail.

The algorithm is held in a small lookup table. The table gives, for each element, the direction, the number of operations (one to three), the operations themselves and a last-element flag. The controller is a four-state machine:

- **ST_IDLE**: waits for start. The transition IDLE→RUN happens on an accepted start.
- **ST_RUN**: issues one memory operation per cycle. At the end of the last element it takes RUN→DRAIN.
- **ST_DRAIN**: lets the final read be compared. It always goes DRAIN→DONE.
- **ST_DONE**: pulses done. It always goes DONE→IDLE.

On the first mismatching read, the sequencer captures the address and the element index of that read. The fail flag then stays set until the next accepted start. An operation counter is exposed so that the cost of the test can be checked.

Top module: `march_bist_engine`

## Requirements
- R1: After reset, busy, done, fail, mem_we and mem_re are 0, and op_count is 0.
- R2: Start is accepted only while busy is 0. An accepted start latches alg_sel, clears op_count and fail, and raises busy in the next cycle. A start seen while busy is 1 (including the done cycle) has no effect on the running test.
- R3: alg_sel selects the algorithm. 0 is MATS: w0; up(r0,w1); up(r1). 1 is MATS+: w0; up(r0,w1); down(r1,w0). 2 is MATS++: w0; up(r0,w1); down(r1,w0,r0). 3 is March X: w0; up(r0,w1); down(r1,w0); up(r0). 4 is March C-: w0; up(r0,w1); up(r1,w0); down(r0,w1); down(r1,w0); up(r0). 5 is March Y: w0; up(r0,w1,r1); down(r1,w0,r0); up(r0). Codes 6 and 7 run MATS.
- R4: Within an element, all of its operations are issued to one address before the address moves. An ascending element visits 0 to 2^ADDR_W-1, and a descending element visits 2^ADDR_W-1 down to 0. The first w0 element and the final lone r0 elements run ascending.
- R5: Exactly one operation is issued per RUN cycle, and mem_we and mem_re are never both 1. A write of value v drives every bit of mem_wdata to v.
- R6: The read data for a read is compared in the cycle after the read is issued, against the expected bit replicated over all DATA_W bits. Any mismatch sets fail.
- R7: The first mismatch latches fail_addr (the address of the read) and fail_elem (the element index, 0 for the first element). These values and fail hold until the next accepted start.
- R8: op_count increments once per issued operation. At done it equals 2^ADDR_W times 4, 5, 6, 6, 10 or 8 for algorithms 0 to 5.
- R9: done is a one-cycle pulse two cycles after the cycle in which the last operation is issued. busy is 1 from the cycle after the accepted start through the done cycle, and 0 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled while idle |
| alg_sel | input | 3 | Algorithm code (see R3) |
| mem_rdata | input | DATA_W | Read data, valid the cycle after mem_re |
| mem_addr | output | ADDR_W | Memory address |
| mem_we | output | 1 | Write enable |
| mem_re | output | 1 | Read enable |
| mem_wdata | output | DATA_W | Write data, all zeros or all ones |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | ADDR_W | Address of first mismatch |
| fail_elem | output | 3 | Element index of first mismatch |
| op_count | output | ADDR_W+4 | Operations issued since start |

## Verification
The bench compares every issued operation against a trace built by an independent model of the algorithms. This catches a design that reverses a descending element, advances the address before an element's operations are finished, or writes the wrong value. Faults injected into the memory model (stuck-at bits at addresses 0 and 2^ADDR_W-1, a cell that cannot rise, and coupling between two cells in both address orders) check that only the first mismatch is captured. A design that kept overwriting the fail address, or that compared data one cycle too early, would report a different address or element. Start pulses in the middle of a run and in the done cycle would change the operation count or restart the test if the busy guard were missing. Alias codes 6 and 7, and the exact done latency, are checked directly.

// File: rtl/march_pkg.sv
package march_pkg;

    localparam int ELEM_W = 3;

    // operation code: bit1 = write, bit0 = data value
    localparam logic [1:0] OP_R0 = 2'b00;
    localparam logic [1:0] OP_R1 = 2'b01;
    localparam logic [1:0] OP_W0 = 2'b10;
    localparam logic [1:0] OP_W1 = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic            down;
        logic            last;
        logic [1:0]      nops_m1;
        logic [2:0][1:0] ops;
    } melem_t;

    function automatic logic march_down(input logic [2:0] alg, input logic [ELEM_W-1:0] idx);
        case (alg)
            3'd1, 3'd2, 3'd3, 3'd5: march_down = (idx == 3'd2);
            3'd4:                   march_down = (idx == 3'd3) || (idx == 3'd4);
            default:                march_down = 1'b0;
        endcase
    endfunction

    function automatic melem_t mk(input logic last, input logic [1:0] n,
                                  input logic [1:0] o0, input logic [1:0] o1,
                                  input logic [1:0] o2);
        melem_t e;
        e.down    = 1'b0;
        e.last    = last;
        e.nops_m1 = n;
        e.ops     = {o2, o1, o0};
        return e;
    endfunction

    function automatic melem_t march_lookup(input logic [2:0] alg, input logic [ELEM_W-1:0] idx);
        melem_t e;
        e = mk(1'b0, 2'd0, OP_W0, OP_W0, OP_W0);
        case (alg)
            3'd1: case (idx)
                3'd1:    e = mk(1'b0, 2'd1, OP_R0, OP_W1, OP_W1);
                3'd2:    e = mk(1'b1, 2'd1, OP_R1, OP_W0, OP_W0);
                default: e = mk(1'b0, 2'd0, OP_W0, OP_W0, OP_W0);
            endcase
            3'd2: case (idx)
                3'd1:    e = mk(1'b0, 2'd1, OP_R0, OP_W1, OP_W1);
                3'd2:    e = mk(1'b1, 2'd2, OP_R1, OP_W0, OP_R0);
                default: e = mk(1'b0, 2'd0, OP_W0, OP_W0, OP_W0);
            endcase
            3'd3: case (idx)
                3'd1:    e = mk(1'b0, 2'd1, OP_R0, OP_W1, OP_W1);
                3'd2:    e = mk(1'b0, 2'd1, OP_R1, OP_W0, OP_W0);
                3'd3:    e = mk(1'b1, 2'd0, OP_R0, OP_R0, OP_R0);
                default: e = mk(1'b0, 2'd0, OP_W0, OP_W0, OP_W0);
            endcase
            3'd4: case (idx)
                3'd1, 3'd3: e = mk(1'b0, 2'd1, OP_R0, OP_W1, OP_W1);
                3'd2, 3'd4: e = mk(1'b0, 2'd1, OP_R1, OP_W0, OP_W0);
                3'd5:       e = mk(1'b1, 2'd0, OP_R0, OP_R0, OP_R0);
                default:    e = mk(1'b0, 2'd0, OP_W0, OP_W0, OP_W0);
            endcase
            3'd5: case (idx)
                3'd1:    e = mk(1'b0, 2'd2, OP_R0, OP_W1, OP_R1);
                3'd2:    e = mk(1'b0, 2'd2, OP_R1, OP_W0, OP_R0);
                3'd3:    e = mk(1'b1, 2'd0, OP_R0, OP_R0, OP_R0);
                default: e = mk(1'b0, 2'd0, OP_W0, OP_W0, OP_W0);
            endcase
            default: case (idx)
                3'd1:    e = mk(1'b0, 2'd1, OP_R0, OP_W1, OP_W1);
                3'd2:    e = mk(1'b1, 2'd0, OP_R1, OP_R1, OP_R1);
                default: e = mk(1'b0, 2'd0, OP_W0, OP_W0, OP_W0);
            endcase
        endcase
        e.down = march_down(alg, idx);
        return e;
    endfunction

endpackage

// File: rtl/march_table.sv
module march_table
    import march_pkg::*;
(
    input  logic [2:0]        alg,
    input  logic [ELEM_W-1:0] idx,
    output melem_t            elem,
    output logic              next_down
);
    logic [ELEM_W-1:0] idx_nx;

    assign idx_nx = idx + 1'b1;

    always_comb begin
        elem      = march_lookup(alg, idx);
        next_down = march_down(alg, idx_nx);
    end
endmodule

// File: rtl/march_addr_ctr.sv
module march_addr_ctr #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_down,
    input  logic              step,
    input  logic              down,
    output logic [ADDR_W-1:0] addr,
    output logic              at_end
);
    localparam logic [ADDR_W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= load_down ? TOP : '0;
        else if (step)
            addr <= down ? addr - 1'b1 : addr + 1'b1;
    end

    assign at_end = down ? (addr == '0) : (addr == TOP);
endmodule

// File: rtl/march_resp_chk.sv
module march_resp_chk
    import march_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              rd_issue,
    input  logic              exp_bit,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ELEM_W-1:0] rd_elem,
    input  logic [DATA_W-1:0] rdata,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [ELEM_W-1:0] fail_elem
);
    logic              pend_q;
    logic              pexp_q;
    logic [ADDR_W-1:0] paddr_q;
    logic [ELEM_W-1:0] pelem_q;
    logic              miss;

    assign miss = pend_q && (rdata != {DATA_W{pexp_q}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            pexp_q    <= 1'b0;
            paddr_q   <= '0;
            pelem_q   <= '0;
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_elem <= '0;
        end else if (clear) begin
            pend_q    <= 1'b0;
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_elem <= '0;
        end else begin
            pend_q  <= rd_issue;
            pexp_q  <= exp_bit;
            paddr_q <= rd_addr;
            pelem_q <= rd_elem;
            if (miss && !fail) begin
                fail      <= 1'b1;
                fail_addr <= paddr_q;
                fail_elem <= pelem_q;
            end
        end
    end
endmodule

// File: rtl/march_bist_engine.sv
module march_bist_engine
    import march_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [2:0]          alg_sel,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_we,
    output logic                mem_re,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                busy,
    output logic                done,
    output logic                fail,
    output logic [ADDR_W-1:0]   fail_addr,
    output logic [ELEM_W-1:0]   fail_elem,
    output logic [ADDR_W+3:0]   op_count
);
    localparam int CNT_W = ADDR_W + 4;

    seq_state_e        st_q, st_d;
    logic [2:0]        alg_q;
    logic [ELEM_W-1:0] elem_q;
    logic [1:0]        opi_q;
    logic [CNT_W-1:0]  cnt_q;
    melem_t            cur_e;
    logic              next_down;
    logic [1:0]        cur_op;
    logic [ADDR_W-1:0] addr;
    logic              at_end;
    logic              running, accept, op_last;

    assign running = (st_q == ST_RUN);
    assign accept  = (st_q == ST_IDLE) && start;
    assign cur_op  = cur_e.ops[opi_q];
    assign op_last = (opi_q == cur_e.nops_m1);

    march_table u_table (
        .alg       (alg_q),
        .idx       (elem_q),
        .elem      (cur_e),
        .next_down (next_down)
    );

    march_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept || (running && op_last && at_end && !cur_e.last)),
        .load_down (accept ? 1'b0 : next_down),
        .step      (running && op_last && !at_end),
        .down      (cur_e.down),
        .addr      (addr),
        .at_end    (at_end)
    );

    march_resp_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .rd_issue  (running && !cur_op[1]),
        .exp_bit   (cur_op[0]),
        .rd_addr   (addr),
        .rd_elem   (elem_q),
        .rdata     (mem_rdata),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_elem (fail_elem)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start) st_d = ST_RUN;
            ST_RUN:   if (op_last && at_end && cur_e.last) st_d = ST_DRAIN;
            ST_DRAIN: st_d = ST_DONE;
            ST_DONE:  st_d = ST_IDLE;
        endcase
    end

    // sequence position and operation counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alg_q  <= '0;
            elem_q <= '0;
            opi_q  <= '0;
            cnt_q  <= '0;
        end else if (accept) begin
            alg_q  <= alg_sel;
            elem_q <= '0;
            opi_q  <= '0;
            cnt_q  <= '0;
        end else if (running) begin
            cnt_q <= cnt_q + 1'b1;
            if (!op_last) begin
                opi_q <= opi_q + 1'b1;
            end else begin
                opi_q <= '0;
                if (at_end && !cur_e.last) elem_q <= elem_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        mem_addr  = addr;
        mem_we    = running && cur_op[1];
        mem_re    = running && !cur_op[1];
        mem_wdata = {DATA_W{cur_op[0]}};
        busy      = (st_q != ST_IDLE);
        done      = (st_q == ST_DONE);
        op_count  = cnt_q;
    end
endmodule

// File: rtl/march_bist_engine_sva.sv
module march_bist_engine_sva #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_we,
    input logic              mem_re,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [2:0]        fail_elem,
    input logic [ADDR_W+3:0] op_count
);
    localparam int CNT_W = ADDR_W + 4;
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    AST_ACCESS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R5

    AST_WDATA_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == '0 || mem_wdata == '1)); // R5

    AST_ACCESS_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> busy); // R9

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9

    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !(start && !busy)) |=> (fail && $stable(fail_addr) && $stable(fail_elem))); // R7

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |=> (op_count == $past(op_count) + ONE)); // R8
endmodule

bind march_bist_engine march_bist_engine_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .fail_addr (fail_addr),
    .fail_elem (fail_elem),
    .op_count  (op_count)
);

// File: tb/test_march_bist_engine.sv
`timescale 1ns/1ps
module test_march_bist_engine;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N = 1 << AW;
    localparam int MAXOPS = 10 * N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] alg_sel = '0;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] mem_addr;
    logic mem_we, mem_re;
    logic [DW-1:0] mem_wdata;
    logic busy, done, fail;
    logic [AW-1:0] fail_addr;
    logic [2:0] fail_elem;
    logic [AW+3:0] op_count;

    always #10 clk = ~clk;   // 50 MHz

    march_bist_engine #(.ADDR_W(AW), .DATA_W(DW)) i_march_bist_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .alg_sel(alg_sel),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_re(mem_re), .mem_wdata(mem_wdata), .busy(busy), .done(done),
        .fail(fail), .fail_addr(fail_addr), .fail_elem(fail_elem),
        .op_count(op_count)
    );

    int checks = 0;
    int failures = 0;

    // fault model: 0 none, 1 bit0 stuck 0, 2 bit0 stuck 1,
    // 3 bit0 cannot rise, 4 rising bit0 at fb clears bit0 at fa
    int fk = 0;
    int fa = 0;
    int fb = 1;

    logic [DW-1:0] dmem [N];
    logic [DW-1:0] rmem [N];
    logic [DW-1:0] img  [N];
    logic          ld = 1'b0;
    logic [DW-1:0] mold;

    function automatic logic [DW-1:0] rd_f(input logic [DW-1:0] v, input int a);
        logic [DW-1:0] r = v;
        if (a == fa && fk == 1) r[0] = 1'b0;
        if (a == fa && fk == 2) r[0] = 1'b1;
        return r;
    endfunction

    function automatic logic [DW-1:0] st_f(input int a, input logic [DW-1:0] old, input logic [DW-1:0] d);
        logic [DW-1:0] r = d;
        if (a == fa && fk == 3 && !old[0] && d[0]) r[0] = 1'b0;
        if (a == fa && fk == 1) r[0] = 1'b0;
        if (a == fa && fk == 2) r[0] = 1'b1;
        return r;
    endfunction

    always @(posedge clk) begin
        if (ld) begin
            for (int i = 0; i < N; i++) dmem[i] = img[i];
        end else begin
            if (mem_re) mem_rdata <= rd_f(dmem[mem_addr], int'(mem_addr));
            if (mem_we) begin
                mold = dmem[mem_addr];
                dmem[mem_addr] = st_f(int'(mem_addr), mold, mem_wdata);
                if (fk == 4 && int'(mem_addr) == fb && !mold[0] && mem_wdata[0])
                    dmem[fa][0] = 1'b0;
            end
        end
    end

    // expected algorithm description: {down, last, nops-1, op2, op1, op0}
    // op code: bit1 write, bit0 value
    function automatic logic [9:0] be(input bit dn, input bit last, input int n,
                                      input logic [1:0] o0, input logic [1:0] o1, input logic [1:0] o2);
        return {dn, last, 2'(n - 1), o2, o1, o0};
    endfunction

    function automatic logic [9:0] elem_desc(input int alg, input int e);
        localparam logic [1:0] R0 = 0, R1 = 1, W0 = 2, W1 = 3;
        if (e == 0) return be(0, 0, 1, W0, W0, W0);
        case (alg)
            1: return (e == 1) ? be(0, 0, 2, R0, W1, W1) : be(1, 1, 2, R1, W0, W0);
            2: return (e == 1) ? be(0, 0, 2, R0, W1, W1) : be(1, 1, 3, R1, W0, R0);
            3: case (e)
                1: return be(0, 0, 2, R0, W1, W1);
                2: return be(1, 0, 2, R1, W0, W0);
                default: return be(0, 1, 1, R0, R0, R0);
               endcase
            4: case (e)
                1: return be(0, 0, 2, R0, W1, W1);
                2: return be(0, 0, 2, R1, W0, W0);
                3: return be(1, 0, 2, R0, W1, W1);
                4: return be(1, 0, 2, R1, W0, W0);
                default: return be(0, 1, 1, R0, R0, R0);
               endcase
            5: case (e)
                1: return be(0, 0, 3, R0, W1, R1);
                2: return be(1, 0, 3, R1, W0, R0);
                default: return be(0, 1, 1, R0, R0, R0);
               endcase
            default: return (e == 1) ? be(0, 0, 2, R0, W1, W1) : be(0, 1, 1, R1, R1, R1);
        endcase
    endfunction

    function automatic int cost(input int alg);
        case (alg)
            1: return 5; 2: return 6; 3: return 6; 4: return 10; 5: return 8;
            default: return 4;
        endcase
    endfunction

    logic [AW-1:0] tr_addr [MAXOPS];
    logic          tr_we   [MAXOPS];
    logic          tr_val  [MAXOPS];
    int  k_ops;
    bit  exp_fail;
    int  exp_addr, exp_elem;

    task automatic ref_run(input int alg);
        int e = 0;
        bit fin = 0;
        k_ops = 0; exp_fail = 0; exp_addr = 0; exp_elem = 0;
        while (!fin) begin
            logic [9:0] d = elem_desc(alg, e);
            for (int i = 0; i < N; i++) begin
                int a = d[9] ? N - 1 - i : i;
                for (int k = 0; k <= int'(d[7:6]); k++) begin
                    logic [1:0] op = d[2*k +: 2];
                    tr_addr[k_ops] = AW'(a); tr_we[k_ops] = op[1]; tr_val[k_ops] = op[0];
                    k_ops++;
                    if (op[1]) begin
                        logic [DW-1:0] o = rmem[a];
                        rmem[a] = st_f(a, o, {DW{op[0]}});
                        if (fk == 4 && a == fb && !o[0] && op[0]) rmem[fa][0] = 1'b0;
                    end else if (rd_f(rmem[a], a) != {DW{op[0]}} && !exp_fail) begin
                        exp_fail = 1; exp_addr = a; exp_elem = e;
                    end
                end
            end
            fin = d[8];
            e++;
        end
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // intr: 1 = extra start mid-run and in the done cycle
    task automatic run_case(input int alg, input int kind, input int va, input int ag, input bit intr);
        int cnt = 0;
        int mptr = 0;
        int terr = 0;
        logic [AW+3:0] cnt_at_done;
        fk = kind; fa = va; fb = ag;
        for (int i = 0; i < N; i++) begin
            img[i] = DW'($urandom);
            rmem[i] = img[i];
        end
        @(negedge clk); ld = 1'b1;
        @(negedge clk); ld = 1'b0;
        ref_run(alg % 8 > 5 ? 0 : alg);
        start = 1'b1; alg_sel = 3'(alg);
        while (1) begin
            @(negedge clk);
            cnt++;
            start = 1'b0;
            if (cnt == 1) check(busy === 1'b1, "R2 busy after start", busy, 1);
            if (intr && cnt == 5) begin start = 1'b1; alg_sel = 3'd4; end
            if (mem_we || mem_re) begin
                if (mptr >= k_ops || mem_we !== tr_we[mptr] || mem_addr !== tr_addr[mptr] ||
                    (mem_we && mem_wdata !== {DW{tr_val[mptr]}}))
                    terr++;
                mptr++;
            end
            if (done === 1'b1 || cnt > 4 * MAXOPS) break;
        end
        check(cnt == k_ops + 2, "R9 done latency", cnt, k_ops + 2);
        check(terr == 0 && mptr == k_ops, "R4 operation order", terr, 0);
        check(int'(op_count) == k_ops && k_ops == cost(alg % 8 > 5 ? 0 : alg) * N,
              "R8 op_count at done", op_count, cost(alg % 8 > 5 ? 0 : alg) * N);
        check(fail === exp_fail, "R6 fail flag", fail, exp_fail);
        if (exp_fail) begin
            check(int'(fail_addr) == exp_addr, "R7 fail_addr", fail_addr, exp_addr);
            check(int'(fail_elem) == exp_elem, "R7 fail_elem", fail_elem, exp_elem);
        end
        cnt_at_done = op_count;
        if (intr) begin start = 1'b1; alg_sel = 3'd5; end
        @(negedge clk);
        start = 1'b0;
        check(done === 1'b0, "R9 done single cycle", done, 0);
        check(busy === 1'b0 && op_count == cnt_at_done, "R2 start in done cycle ignored", busy, 0);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd7731));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && fail === 1'b0, "R1 reset flags", {busy, done, fail}, 0);
        check(mem_we === 1'b0 && mem_re === 1'b0 && op_count == 0, "R1 reset memory port", {mem_we, mem_re}, 0);

        // R3: every algorithm, fault-free
        for (int a = 0; a < 6; a++) run_case(a, 0, 0, 1, 0);
        // R3: alias codes
        run_case(6, 0, 0, 1, 0);
        run_case(7, 1, 2, 1, 0);
        // R6 R7: directed faults at the address extremes
        run_case(1, 1, 0, 1, 0);
        run_case(1, 2, N - 1, 0, 0);
        run_case(0, 3, 5, 0, 0);
        run_case(4, 4, 3, 9, 0);
        run_case(4, 4, 9, 3, 0);
        run_case(5, 1, 7, 0, 0);
        run_case(2, 3, N - 1, 0, 0);
        // R2: start while busy
        run_case(1, 1, 6, 0, 1);
        // constrained random
        for (int r = 0; r < 16; r++) begin
            int a = $urandom % 6;
            int k = $urandom % 5;
            int v = $urandom % N;
            int g = (v + 1 + ($urandom % (N - 1))) % N;
            run_case(a, k, v, g, r % 4 == 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule